// File: doc/BRIEF.md
# Caliper BCD Digit Frame Decoder

This block decodes the decimal-digit serial format sent by some digital measuring scales. The scale sends its displayed reading as a burst of nibbles on a clock line and a data line. The block takes both lines after they have been synchronised to the system clock. It first waits for a quiet interval on the scale clock, which marks a burst boundary. It then shifts in 28 data bits, taking one bit on each falling edge of the scale clock.

A frame holds six BCD display digits, least significant digit first, then a status nibble. The status nibble carries a sign flag, a half-thousandth flag, a units flag and a marker bit that is always set. Bits arrive low bit first, so each nibble fills from bit 0 upward. A frame passes the check when its marker is set and every digit is in the range 0 to 9. For a passing frame the block updates its registered outputs and raises a one-cycle strobe. A failing frame sets an error flag and leaves the last good reading in place.

The parameters set the quiet-interval length in system clock cycles, the number of digits and whether the digit range check is built in.

Top module: `cal_bcd_decoder`

## Requirements
- R1: While reset is applied and after it is released, `digits_o`, `negative_o`, `half_o`, `metric_o`, `frame_err_o` and `valid_o` are all 0 until a frame completes.
- R2: No capture starts until the scale clock line has been free of edges for `GAP_CYCLES` system cycles. Falling edges of a burst that begins before such a gap produce no output.
- R3: One data bit is captured on each falling edge of the scale clock, and the first bit received becomes frame bit 0. Digit k (k = 0 for the least significant digit) is frame bits 4k+3..4k, and it appears at `digits_o[4k+3:4k]`.
- R4: The status nibble is frame bits 27..24. Bit 24 is the sign (1 = negative), bit 25 adds half a thousandth of an inch, bit 26 selects millimetres, and bit 27 is the marker. They appear on `negative_o`, `half_o` and `metric_o`.
- R5: A frame whose marker is 1 and whose digits are all 9 or less raises `valid_o` for exactly one system cycle, clears `frame_err_o`, and loads the decoded outputs.
- R6: A frame whose marker bit is 0 sets `frame_err_o`, gives no `valid_o` pulse, and leaves the digit and flag outputs unchanged.
- R7: A frame in which any digit nibble is greater than 9 sets `frame_err_o`, gives no `valid_o` pulse, and leaves the digit and flag outputs unchanged.
- R8: A quiet interval of `GAP_CYCLES` inside a partly received frame discards the partial bits. The following complete frame is then decoded on its own.
- R9: The digit and flag outputs change only in the cycle in which `valid_o` is high, and otherwise hold their last good values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scale_clk_i | input | 1 | Synchronised scale clock line |
| scale_dat_i | input | 1 | Synchronised scale data line |
| digits_o | output | 4*NUM_DIGITS | BCD digits, least significant digit in bits 3..0 |
| negative_o | output | 1 | Reading is negative |
| half_o | output | 1 | Reading includes an extra half thousandth |
| metric_o | output | 1 | Reading is in millimetres |
| frame_err_o | output | 1 | The last completed frame failed its check |
| valid_o | output | 1 | One-cycle strobe when a good frame is loaded |

## Verification
The hardest case to reach is a burst that is cut off part-way and then followed by a quiet interval. The bench sends only the first twelve bits of one frame, holds the clock line still for longer than the gap time, and then sends a complete frame with different digits. A stale bit count would show up as a mixed reading. A second hard case is a burst that starts straight after reset, before any gap has been seen. The bench starts toggling the lines within a few cycles of reset release and checks that no strobe follows.

// File: rtl/cal_bcd_pkg.sv
package cal_bcd_pkg;
   localparam int unsigned NIB_W = 4;

   typedef enum logic {
      ST_SYNC,
      ST_CAPT
   } cap_state_e;

   typedef struct packed {
      logic marker;
      logic metric;
      logic half;
      logic negative;
   } status_nib_t;
endpackage

// File: rtl/cal_gap_timer.sv
module cal_gap_timer #(
   parameter int unsigned GAP_CYCLES = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic fall_o,
   output logic idle_o
);
   localparam int unsigned CW = $clog2(GAP_CYCLES + 1);
   localparam logic [CW-1:0] GAP_MAX = CW'(GAP_CYCLES);

   logic          prev_q;
   logic [CW-1:0] quiet_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         quiet_q <= '0;
      end else begin
         prev_q <= line_i;
         if (line_i != prev_q)
            quiet_q <= '0;
         else if (quiet_q != GAP_MAX)
            quiet_q <= quiet_q + 1'b1;
      end
   end

   assign fall_o = prev_q & ~line_i;
   assign idle_o = (quiet_q == GAP_MAX);
endmodule

// File: rtl/cal_frame_shifter.sv
module cal_frame_shifter #(
   parameter int unsigned FRAME_BITS = 28
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear_i,
   input  logic                  shift_i,
   input  logic                  bit_i,
   output logic [FRAME_BITS-1:0] frame_o,
   output logic                  busy_o,
   output logic                  last_o,
   output logic                  done_o
);
   localparam int unsigned BW = $clog2(FRAME_BITS + 1);
   localparam logic [BW-1:0] LAST_IDX = BW'(FRAME_BITS - 1);

   logic [FRAME_BITS-1:0] sr_q;
   logic [BW-1:0]         cnt_q;
   logic                  done_q;

   assign last_o = shift_i & ~clear_i & (cnt_q == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q   <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (clear_i) begin
            cnt_q <= '0;
         end else if (shift_i) begin
            sr_q <= {bit_i, sr_q[FRAME_BITS-1:1]};
            if (cnt_q == LAST_IDX) begin
               cnt_q  <= '0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign frame_o = sr_q;
   assign busy_o  = (cnt_q != '0);
   assign done_o  = done_q;
endmodule

// File: rtl/cal_frame_check.sv
module cal_frame_check
   import cal_bcd_pkg::*;
#(
   parameter int unsigned NUM_DIGITS   = 6,
   parameter bit          CHECK_DIGITS = 1'b1,
   localparam int unsigned FRAME_BITS  = (NUM_DIGITS + 1) * NIB_W
) (
   input  logic [FRAME_BITS-1:0] frame_i,
   output logic                  good_o
);
   logic [NUM_DIGITS-1:0] digit_ok;
   status_nib_t           stat;

   assign stat = status_nib_t'(frame_i[FRAME_BITS-1 -: NIB_W]);

   for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
      if (CHECK_DIGITS) begin : g_range
         assign digit_ok[k] = (frame_i[k*NIB_W +: NIB_W] <= 4'd9);
      end else begin : g_free
         assign digit_ok[k] = 1'b1;
      end
   end

   assign good_o = stat.marker & (&digit_ok);
endmodule

// File: rtl/cal_bcd_decoder.sv
module cal_bcd_decoder
   import cal_bcd_pkg::*;
#(
   parameter int unsigned GAP_CYCLES   = 50000,
   parameter int unsigned NUM_DIGITS   = 6,
   parameter bit          CHECK_DIGITS = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        scale_clk_i,
   input  logic                        scale_dat_i,
   output logic [NUM_DIGITS*NIB_W-1:0] digits_o,
   output logic                        negative_o,
   output logic                        half_o,
   output logic                        metric_o,
   output logic                        frame_err_o,
   output logic                        valid_o
);
   localparam int unsigned DIG_BITS   = NUM_DIGITS * NIB_W;
   localparam int unsigned FRAME_BITS = DIG_BITS + NIB_W;

   if (GAP_CYCLES < 2) begin : g_bad_gap
      $error("GAP_CYCLES must be at least 2");
   end
   if (NUM_DIGITS < 1) begin : g_bad_dig
      $error("NUM_DIGITS must be at least 1");
   end

   logic                  fall, idle;
   logic                  sh_clear, sh_shift, sh_busy, sh_last, sh_done;
   logic [FRAME_BITS-1:0] frame;
   logic                  good;
   cap_state_e            state_q;
   status_nib_t           stat;

   cal_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (scale_clk_i),
      .fall_o (fall),
      .idle_o (idle)
   );

   always_comb begin
      sh_clear = 1'b0;
      sh_shift = 1'b0;
      if (state_q == ST_SYNC) begin
         sh_clear = 1'b1;
      end else begin
         sh_clear = idle & sh_busy;
         sh_shift = fall;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_SYNC;
      end else begin
         case (state_q)
            ST_SYNC: if (idle) state_q <= ST_CAPT;
            ST_CAPT: if (sh_last) state_q <= ST_SYNC;
            default: state_q <= ST_SYNC;
         endcase
      end
   end

   cal_frame_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (sh_clear),
      .shift_i (sh_shift),
      .bit_i   (scale_dat_i),
      .frame_o (frame),
      .busy_o  (sh_busy),
      .last_o  (sh_last),
      .done_o  (sh_done)
   );

   cal_frame_check #(
      .NUM_DIGITS   (NUM_DIGITS),
      .CHECK_DIGITS (CHECK_DIGITS)
   ) u_check (
      .frame_i (frame),
      .good_o  (good)
   );

   assign stat = status_nib_t'(frame[FRAME_BITS-1 -: NIB_W]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         digits_o    <= '0;
         negative_o  <= 1'b0;
         half_o      <= 1'b0;
         metric_o    <= 1'b0;
         frame_err_o <= 1'b0;
         valid_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (sh_done) begin
            frame_err_o <= ~good;
            if (good) begin
               digits_o   <= frame[DIG_BITS-1:0];
               negative_o <= stat.negative;
               half_o     <= stat.half;
               metric_o   <= stat.metric;
               valid_o    <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cal_bcd_decoder_chk.sv
module cal_bcd_decoder_chk #(
   parameter int unsigned NUM_DIGITS   = 6,
   parameter bit          CHECK_DIGITS = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_DIGITS*4-1:0] digits_o,
   input logic                    negative_o,
   input logic                    half_o,
   input logic                    metric_o,
   input logic                    frame_err_o,
   input logic                    valid_o
);
   function automatic logic all_bcd(input logic [NUM_DIGITS*4-1:0] d);
      logic ok;
      ok = 1'b1;
      for (int k = 0; k < NUM_DIGITS; k++)
         if (d[k*4 +: 4] > 4'd9) ok = 1'b0;
      return ok;
   endfunction

   // R5
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R6
   valid_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !frame_err_o);

   // R9
   hold_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(digits_o));

   // R9
   hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(negative_o) && $stable(half_o) && $stable(metric_o)));

   // R7
   bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && CHECK_DIGITS) |-> all_bcd(digits_o));
endmodule

bind cal_bcd_decoder cal_bcd_decoder_chk #(
   .NUM_DIGITS   (NUM_DIGITS),
   .CHECK_DIGITS (CHECK_DIGITS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .digits_o    (digits_o),
   .negative_o  (negative_o),
   .half_o      (half_o),
   .metric_o    (metric_o),
   .frame_err_o (frame_err_o),
   .valid_o     (valid_o)
);

// File: tb/tb_cal_bcd_decoder.sv
module tb_cal_bcd_decoder;
   localparam int GAP = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b1;
   logic        sdat = 1'b0;
   logic [23:0] digits;
   logic        neg, half, metric, ferr, valid;

   int checks = 0;
   int errors = 0;
   int vcnt   = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   cal_bcd_decoder #(.GAP_CYCLES(GAP)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scale_clk_i (sclk),
      .scale_dat_i (sdat),
      .digits_o    (digits),
      .negative_o  (neg),
      .half_o      (half),
      .metric_o    (metric),
      .frame_err_o (ferr),
      .valid_o     (valid)
   );

   always @(negedge clk) if (valid) vcnt++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [27:0] mk(input logic [23:0] d, input logic s,
                                      input logic h, input logic m, input logic mk_bit);
      return {mk_bit, m, h, s, d};
   endfunction

   task automatic send(input logic [27:0] f, input int nbits, input bit with_gap);
      if (with_gap) begin
         sclk = 1'b1;
         repeat (GAP + 20) @(negedge clk);
      end
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk) sdat = f[i];
         repeat (3) @(negedge clk);
         sclk = 1'b0;
         repeat (4) @(negedge clk);
         sclk = 1'b1;
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 digits", digits, 0);
      chk("R1 flags", {neg, half, metric}, 0);
      chk("R1 err/valid", {ferr, valid}, 0);
   endtask

   task automatic t_no_gap();
      int v0 = vcnt;
      send(mk(24'h111111, 1'b0, 1'b0, 1'b0, 1'b1), 28, 1'b0);
      chk("R2 no strobe before gap", vcnt - v0, 0);
      chk("R2 digits untouched", digits, 0);
   endtask

   task automatic t_good(input logic [23:0] d, input logic s, input logic h, input logic m);
      int v0 = vcnt;
      send(mk(d, s, h, m, 1'b1), 28, 1'b1);
      chk("R3 digits", digits, d);
      chk("R4 flags", {neg, half, metric}, {s, h, m});
      chk("R5 one-cycle strobe", vcnt - v0, 1);
      chk("R5 err clear", ferr, 0);
   endtask

   task automatic t_bad(input string req, input logic [27:0] f);
      int v0 = vcnt;
      logic [23:0] d0 = digits;
      logic [2:0]  fl0 = {neg, half, metric};
      send(f, 28, 1'b1);
      chk({req, " err set"}, ferr, 1);
      chk({req, " no strobe"}, vcnt - v0, 0);
      chk({req, " digits held"}, digits, d0);
      chk({req, " flags held"}, {neg, half, metric}, fl0);
   endtask

   task automatic t_abort();
      int v0 = vcnt;
      send(mk(24'h999999, 1'b1, 1'b1, 1'b1, 1'b1), 12, 1'b1);
      send(mk(24'h205813, 1'b0, 1'b1, 1'b0, 1'b1), 28, 1'b1);
      chk("R8 digits after abort", digits, 24'h205813);
      chk("R8 flags after abort", {neg, half, metric}, 3'b010);
      chk("R8 single strobe", vcnt - v0, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_gap();
      t_good(24'h012345, 1'b0, 1'b0, 1'b0);
      t_good(24'h987650, 1'b1, 1'b1, 1'b1);
      t_bad("R6", mk(24'h444444, 1'b0, 1'b0, 1'b0, 1'b0));
      t_bad("R7", mk(24'h1A2345, 1'b1, 1'b0, 1'b1, 1'b1));
      // R9: good frame after an error clears the flag and loads new data
      t_good(24'h000007, 1'b0, 1'b1, 1'b0);
      t_abort();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(negedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule